// File: doc/BRIEF.md
# Shared PHY and EEPROM Word Access Sequencer

This block gives a host on an 8-bit register bus access to two 16-bit word stores: a PHY register file and an EEPROM. Both are reached through the same three registers. A control byte starts an operation and picks the target. An address byte carries a 6-bit word offset in its low bits and a 2-bit PHY number in its top bits. A 16-bit data word sits at two byte addresses, low byte first. For a write, the host first loads the data word, then the address, then the control byte. For a read, it loads the address and then the control byte. It then polls the busy flag and writes zero to the control byte when the operation is finished.

Each back end sees a plain request/acknowledge word port. The request stays high, with stable operands, until the back end acknowledges it. A built-in timeout makes sure that busy always clears within a bounded number of cycles, even if a back end never answers. A PHY command that names a PHY number other than the internal one never reaches a port. It finishes after a single busy cycle.

Top module: `shared_word_seq`

## Requirements
- R1: After reset, the control (0x0B), address (0x0C), data-low (0x0D) and data-high (0x0E) registers read 0, and neither request is high.
- R2: Register map: the address and the two data bytes read back what was last written to them. The control byte reads back as {3'b0, write-enable qualifier (bit 4), target select (bit 3), read command (bit 2), write command (bit 1), busy (bit 0)}. Any other address reads 0, and writes to it change nothing.
- R3: Writing control with bit 2 set while idle starts a read. Busy (control bit 0) reads 1 from the cycle after that write.
- R4: A write starts only when bits 1 and 4 are both set. Bit 1 without bit 4 starts nothing. When bit 2 is set, the command is a read whatever bits 1 and 4 hold.
- R5: Control bit 3 = 0 targets the EEPROM port. Bit 3 = 1 with address bits 7:6 = 01 targets the PHY port. In both cases the word offset is address bits 5:0.
- R6: At most one request is high at a time. It stays high with stable operands until its ack. Busy clears the cycle after the ack, and a read loads the returned word into the data register.
- R7: A write presents the data register on the selected port's write data with its write-enable high.
- R8: A PHY command whose address bits 7:6 are not 01 raises no request. Busy is high for exactly one cycle. A read returns 0xFFFF, and a write changes no store.
- R9: While busy, every register write (control, address and data) is ignored.
- R10: If no ack arrives, busy clears after TMO_CYC cycles, and a read then loads 0xFFFF.
- R11: Writing 0 to control while idle clears all of its stored command bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the addressed register |
| phy_req | output | 1 | PHY word request |
| phy_we | output | 1 | PHY request is a write |
| phy_addr | output | OFF_W | PHY word offset |
| phy_wdata | output | WORD_W | PHY write word |
| phy_ack | input | 1 | PHY completion, one cycle |
| phy_rdata | input | WORD_W | PHY read word, valid with ack |
| rom_req | output | 1 | EEPROM word request |
| rom_we | output | 1 | EEPROM request is a write |
| rom_addr | output | OFF_W | EEPROM word offset |
| rom_wdata | output | WORD_W | EEPROM write word |
| rom_ack | input | 1 | EEPROM completion, one cycle |
| rom_rdata | input | WORD_W | EEPROM read word, valid with ack |

## Verification
The timeout path is the hardest case to reach from the ports, because a normal back end always answers. The bench's EEPROM stub has a switch that silences its acknowledge. With the switch on, the bench counts polls until busy clears and checks that a read then yields all ones. A second hard case is a command that arrives while an operation is still running. The bench writes new control, address and data values right after a start, while the slow EEPROM stub is still pending. It then shows through readback and the PHY port that none of those writes had any effect.

// File: rtl/shared_word_pkg.sv
// Shared constants and types for the shared word access sequencer.
// Assumes an 8-bit register bus; byte offsets are fixed here.
package shared_word_pkg;
    localparam logic [7:0] OFS_CTRL = 8'h0B;
    localparam logic [7:0] OFS_ADDR = 8'h0C;
    localparam logic [7:0] OFS_DLO  = 8'h0D;

    localparam int CB_BUSY = 0;
    localparam int CB_WR   = 1;
    localparam int CB_RD   = 2;
    localparam int CB_SEL  = 3;
    localparam int CB_WEN  = 4;

    typedef enum logic [1:0] {TGT_NONE, TGT_PHY, TGT_ROM} tgt_e;
    typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_QUICK} st_e;

    typedef struct packed {
        logic go;
        logic rd;
        tgt_e tgt;
    } cmd_t;
endpackage

// File: rtl/swp_regs.sv
// Host-visible register set: control, address and data bytes.
// Decodes commands written to control. All host writes are dropped
// while busy. The data word is loaded from the sequencer on read completion.
module swp_regs
    import shared_word_pkg::*;
#(
    parameter int WORD_W    = 16,
    parameter int OFF_W     = 6,
    parameter int PHY_SEL_W = 2,
    parameter logic [PHY_SEL_W-1:0] LOCAL_PHY = 2'b01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [7:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              busy,
    input  logic              load_en,
    input  logic [WORD_W-1:0] load_val,
    output cmd_t              cmd,
    output logic [7:0]        addr_q,
    output logic [WORD_W-1:0] data_q
);
    localparam int NBYTES = WORD_W / 8;
    localparam int AW     = OFF_W + PHY_SEL_W;

    logic       host_wr;
    logic [3:0] ctrl_q;
    logic [7:0] lane_q [NBYTES];

    assign host_wr = reg_we && !busy;

    // Control bits 4:1 storage
    always_ff @(posedge clk) begin
        if (!rst_n)                               ctrl_q <= '0;
        else if (host_wr && reg_addr == OFS_CTRL) ctrl_q <= reg_wdata[CB_WEN:CB_WR];
    end

    // Address byte storage
    always_ff @(posedge clk) begin
        if (!rst_n)                               addr_q <= '0;
        else if (host_wr && reg_addr == OFS_ADDR) addr_q <= reg_wdata;
    end

    // One byte lane of the data word per generate pass
    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n)       lane_q[b] <= '0;
            else if (load_en) lane_q[b] <= load_val[b*8 +: 8];
            else if (host_wr && reg_addr == OFS_DLO + 8'(b))
                              lane_q[b] <= reg_wdata;
        end
        assign data_q[b*8 +: 8] = lane_q[b];
    end

    // Command decode from a control write
    always_comb begin
        cmd.go  = host_wr && reg_addr == OFS_CTRL &&
                  (reg_wdata[CB_RD] || (reg_wdata[CB_WR] && reg_wdata[CB_WEN]));
        cmd.rd  = reg_wdata[CB_RD];
        if (!reg_wdata[CB_SEL])                        cmd.tgt = TGT_ROM;
        else if (addr_q[AW-1 -: PHY_SEL_W] == LOCAL_PHY) cmd.tgt = TGT_PHY;
        else                                           cmd.tgt = TGT_NONE;
    end

    // Readback multiplexer
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == OFS_CTRL) reg_rdata = {3'b000, ctrl_q, busy};
        if (reg_addr == OFS_ADDR) reg_rdata = addr_q;
        for (int b = 0; b < NBYTES; b++)
            if (reg_addr == OFS_DLO + 8'(b)) reg_rdata = lane_q[b];
    end
endmodule

// File: rtl/swp_ctrl.sv
// Operation sequencer: holds busy, waits for the selected ack or times out,
// and produces the word to load into the data register on completion.
// Assumes ack is a one-cycle pulse that is only seen while a request is open.
module swp_ctrl
    import shared_word_pkg::*;
#(
    parameter int WORD_W  = 16,
    parameter int TMO_CYC = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_t              cmd,
    input  logic              ack,
    input  logic [WORD_W-1:0] rdata,
    output logic              busy,
    output tgt_e              active_tgt,
    output logic              op_rd,
    output logic              load_en,
    output logic [WORD_W-1:0] load_val
);
    localparam int TW = $clog2(TMO_CYC + 1);

    st_e         state;
    tgt_e        tgt_q;
    logic [TW-1:0] tmr;
    logic        finish;
    logic        expired;

    assign expired = (tmr == TW'(TMO_CYC - 1));
    assign finish  = (state == ST_QUICK) || (state == ST_WAIT && (ack || expired));

    // State, target latch and timeout counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            tgt_q <= TGT_NONE;
            op_rd <= 1'b0;
            tmr   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (cmd.go) begin
                    tgt_q <= cmd.tgt;
                    op_rd <= cmd.rd;
                    tmr   <= '0;
                    state <= (cmd.tgt == TGT_NONE) ? ST_QUICK : ST_WAIT;
                end
                ST_WAIT: begin
                    if (finish) state <= ST_IDLE;
                    else        tmr   <= tmr + 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Completion data: back-end word on ack, all ones otherwise
    assign load_en    = finish && op_rd;
    assign load_val   = (state == ST_WAIT && ack) ? rdata : '1;
    assign busy       = (state != ST_IDLE);
    assign active_tgt = (state == ST_WAIT) ? tgt_q : TGT_NONE;
endmodule

// File: rtl/swp_route.sv
// Steers the open request to one back-end port and selects its ack and data.
// Assumes operands come from registers that are frozen while busy.
module swp_route
    import shared_word_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int OFF_W  = 6
) (
    input  tgt_e              active_tgt,
    input  logic              op_rd,
    input  logic [OFF_W-1:0]  offset,
    input  logic [WORD_W-1:0] wdata,
    output logic              phy_req,
    output logic              phy_we,
    output logic [OFF_W-1:0]  phy_addr,
    output logic [WORD_W-1:0] phy_wdata,
    input  logic              phy_ack,
    input  logic [WORD_W-1:0] phy_rdata,
    output logic              rom_req,
    output logic              rom_we,
    output logic [OFF_W-1:0]  rom_addr,
    output logic [WORD_W-1:0] rom_wdata,
    input  logic              rom_ack,
    input  logic [WORD_W-1:0] rom_rdata,
    output logic              ack,
    output logic [WORD_W-1:0] rdata
);
    // Request and operand fan-out
    assign phy_req   = (active_tgt == TGT_PHY);
    assign rom_req   = (active_tgt == TGT_ROM);
    assign phy_we    = !op_rd;
    assign rom_we    = !op_rd;
    assign phy_addr  = offset;
    assign rom_addr  = offset;
    assign phy_wdata = wdata;
    assign rom_wdata = wdata;

    // Return path: only the port with an open request counts
    always_comb begin
        ack   = (phy_req && phy_ack) || (rom_req && rom_ack);
        rdata = phy_req ? phy_rdata : rom_rdata;
    end
endmodule

// File: rtl/shared_word_seq.sv
// Top of the shared PHY/EEPROM word access sequencer.
// Joins the register set, the sequencer and the port router.
module shared_word_seq
    import shared_word_pkg::*;
#(
    parameter int WORD_W    = 16,
    parameter int OFF_W     = 6,
    parameter int PHY_SEL_W = 2,
    parameter logic [PHY_SEL_W-1:0] LOCAL_PHY = 2'b01,
    parameter int TMO_CYC   = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [7:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              phy_req,
    output logic              phy_we,
    output logic [OFF_W-1:0]  phy_addr,
    output logic [WORD_W-1:0] phy_wdata,
    input  logic              phy_ack,
    input  logic [WORD_W-1:0] phy_rdata,
    output logic              rom_req,
    output logic              rom_we,
    output logic [OFF_W-1:0]  rom_addr,
    output logic [WORD_W-1:0] rom_wdata,
    input  logic              rom_ack,
    input  logic [WORD_W-1:0] rom_rdata
);
    cmd_t              cmd;
    logic              busy;
    logic [7:0]        addr_q;
    logic [WORD_W-1:0] data_q;
    logic              load_en;
    logic [WORD_W-1:0] load_val;
    tgt_e              active_tgt;
    logic              op_rd;
    logic              ack;
    logic [WORD_W-1:0] rdata;

    swp_regs #(
        .WORD_W(WORD_W), .OFF_W(OFF_W), .PHY_SEL_W(PHY_SEL_W), .LOCAL_PHY(LOCAL_PHY)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .busy(busy), .load_en(load_en), .load_val(load_val),
        .cmd(cmd), .addr_q(addr_q), .data_q(data_q)
    );

    swp_ctrl #(.WORD_W(WORD_W), .TMO_CYC(TMO_CYC)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .ack(ack), .rdata(rdata),
        .busy(busy), .active_tgt(active_tgt), .op_rd(op_rd),
        .load_en(load_en), .load_val(load_val)
    );

    swp_route #(.WORD_W(WORD_W), .OFF_W(OFF_W)) u_route (
        .active_tgt(active_tgt), .op_rd(op_rd),
        .offset(addr_q[OFF_W-1:0]), .wdata(data_q),
        .phy_req(phy_req), .phy_we(phy_we), .phy_addr(phy_addr), .phy_wdata(phy_wdata),
        .phy_ack(phy_ack), .phy_rdata(phy_rdata),
        .rom_req(rom_req), .rom_we(rom_we), .rom_addr(rom_addr), .rom_wdata(rom_wdata),
        .rom_ack(rom_ack), .rom_rdata(rom_rdata),
        .ack(ack), .rdata(rdata)
    );
endmodule

// File: rtl/swp_check.sv
// Protocol checker for shared_word_seq, attached by bind below.
// Assumes the default 8-bit address register layout.
module swp_check #(
    parameter int TMO_CYC = 64
) (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_we,
    input logic [7:0] reg_addr,
    input logic [7:0] reg_wdata,
    input logic       busy,
    input logic [7:0] addr_q,
    input logic       phy_req,
    input logic       phy_ack,
    input logic       rom_req,
    input logic       rom_ack,
    input logic [5:0] rom_addr,
    input logic       rom_we
);
    localparam int CW = $clog2(TMO_CYC + 2);
    logic [CW-1:0] busy_run;
    logic          start_wr;

    assign start_wr = reg_we && reg_addr == 8'h0B && !busy &&
                      (reg_wdata[2] || (reg_wdata[1] && reg_wdata[4]));

    // Length of the current busy run
    always_ff @(posedge clk) begin
        if (!rst_n)    busy_run <= '0;
        else if (busy) busy_run <= busy_run + 1'b1;
        else           busy_run <= '0;
    end

    assert_busy_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start_wr |=> busy);
    assert_no_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 8'h0B && !busy && !reg_wdata[2] && !(reg_wdata[1] && reg_wdata[4])) |=> !busy);
    assert_one_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({phy_req, rom_req}));
    assert_req_in_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_req || rom_req) |-> busy);
    assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ((phy_req && phy_ack) || (rom_req && rom_ack))) |=> !busy);
    assert_rom_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_req && !rom_ack) |=> ($stable(rom_addr) && $stable(rom_we)));
    assert_bad_phy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_wr && reg_wdata[3] && addr_q[7:6] != 2'b01) |=> (busy && !phy_req && !rom_req) ##1 !busy);
    assert_addr_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_we && reg_addr == 8'h0C) |=> $stable(addr_q));
    assert_bounded_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_run < CW'(TMO_CYC)));
endmodule

bind shared_word_seq swp_check #(.TMO_CYC(TMO_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .busy(busy), .addr_q(addr_q), .phy_req(phy_req), .phy_ack(phy_ack),
    .rom_req(rom_req), .rom_ack(rom_ack), .rom_addr(rom_addr), .rom_we(rom_we)
);

// File: tb/test_shared_word_seq.sv
// Bench: behavioural reference model compared every clock, plus directed checks.
module test_shared_word_seq;
    localparam int CLK_PERIOD = 10;
    localparam int TMO = 64;
    localparam int PHY_LAT = 3;
    localparam int ROM_LAT = 5;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        reg_we = 0;
    logic [7:0]  reg_addr = 8'h0B;
    logic [7:0]  reg_wdata = 0;
    logic [7:0]  reg_rdata;
    logic        phy_req, phy_we, rom_req, rom_we;
    logic [5:0]  phy_addr, rom_addr;
    logic [15:0] phy_wdata, rom_wdata, phy_rdata, rom_rdata;
    logic        phy_ack, rom_ack;
    logic        rom_dead = 0;
    logic [15:0] phy_mem [64];
    logic [15:0] rom_mem [64];
    int          phy_cnt, rom_cnt;
    int          n_chk = 0, n_bad = 0;
    bit          fin = 0;
    int          phy_starts = 0;
    logic        phy_req_d;

    always #(CLK_PERIOD/2) clk = ~clk;

    shared_word_seq #(.TMO_CYC(TMO)) i_shared_word_seq (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .phy_req(phy_req), .phy_we(phy_we), .phy_addr(phy_addr), .phy_wdata(phy_wdata),
        .phy_ack(phy_ack), .phy_rdata(phy_rdata),
        .rom_req(rom_req), .rom_we(rom_we), .rom_addr(rom_addr), .rom_wdata(rom_wdata),
        .rom_ack(rom_ack), .rom_rdata(rom_rdata)
    );

    // Fixed-latency back-end stubs with word stores
    assign phy_rdata = phy_mem[phy_addr];
    assign rom_rdata = rom_mem[rom_addr];
    always @(posedge clk) begin
        if (!rst_n) begin
            phy_ack <= 0; rom_ack <= 0; phy_cnt <= 0; rom_cnt <= 0;
            for (int i = 0; i < 64; i++) begin
                phy_mem[i] <= 16'hA000 + 16'(i);
                rom_mem[i] <= 16'hC000 + 16'(i);
            end
        end else begin
            if (phy_req && phy_ack && phy_we) phy_mem[phy_addr] <= phy_wdata;
            if (rom_req && rom_ack && rom_we) rom_mem[rom_addr] <= rom_wdata;
            if (phy_req && !phy_ack) begin
                if (phy_cnt == PHY_LAT-1) begin phy_ack <= 1; phy_cnt <= 0; end
                else phy_cnt <= phy_cnt + 1;
            end else begin phy_ack <= 0; phy_cnt <= 0; end
            if (rom_req && !rom_ack && !rom_dead) begin
                if (rom_cnt == ROM_LAT-1) begin rom_ack <= 1; rom_cnt <= 0; end
                else rom_cnt <= rom_cnt + 1;
            end else begin rom_ack <= 0; rom_cnt <= 0; end
        end
    end

    // Count PHY request starts
    always @(posedge clk) begin
        phy_req_d <= rst_n ? phy_req : 1'b0;
        if (rst_n && phy_req && !phy_req_d) phy_starts++;
    end

    // Reference model (0 idle, 1 waiting, 2 one-cycle finish)
    int         m_st = 0, m_tgt = 0, m_cnt = 0;
    bit         m_rd = 0;
    logic [3:0] m_ctl = 0;
    logic [7:0] m_adr = 0;
    logic [15:0] m_dat = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_tgt = 0; m_cnt = 0; m_rd = 0; m_ctl = 0; m_adr = 0; m_dat = 0;
        end else if (m_st == 1) begin
            if ((m_tgt == 1 && phy_ack) || (m_tgt == 2 && rom_ack)) begin
                if (m_rd) m_dat = (m_tgt == 1) ? phy_mem[m_adr[5:0]] : rom_mem[m_adr[5:0]];
                m_st = 0;
            end else if (m_cnt == TMO-1) begin
                if (m_rd) m_dat = 16'hFFFF;
                m_st = 0;
            end else m_cnt++;
        end else if (m_st == 2) begin
            if (m_rd) m_dat = 16'hFFFF;
            m_st = 0;
        end else if (reg_we) begin
            case (reg_addr)
                8'h0B: begin
                    m_ctl = reg_wdata[4:1];
                    if (reg_wdata[2] || (reg_wdata[1] && reg_wdata[4])) begin
                        m_rd = reg_wdata[2]; m_cnt = 0;
                        if (!reg_wdata[3])              begin m_tgt = 2; m_st = 1; end
                        else if (m_adr[7:6] == 2'b01)   begin m_tgt = 1; m_st = 1; end
                        else                            begin m_tgt = 0; m_st = 2; end
                    end
                end
                8'h0C: m_adr = reg_wdata;
                8'h0D: m_dat[7:0] = reg_wdata;
                8'h0E: m_dat[15:8] = reg_wdata;
                default: ;
            endcase
        end
    end

    function automatic logic [7:0] m_read(input logic [7:0] a);
        case (a)
            8'h0B: return {3'b000, m_ctl, m_st != 0};
            8'h0C: return m_adr;
            8'h0D: return m_dat[7:0];
            8'h0E: return m_dat[15:8];
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Per-clock comparison against the model (R2 readback, R6 requests)
    always begin
        @(posedge clk); #1;
        if (rst_n && !fin) begin
            chk("R2 readback", {8'h00, reg_rdata}, {8'h00, m_read(reg_addr)});
            chk("R6 requests", {14'h0, phy_req, rom_req},
                {14'h0, (m_st == 1 && m_tgt == 1), (m_st == 1 && m_tgt == 2)});
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 0; reg_addr = 8'h0B; reg_wdata = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        reg_addr = a; #1; d = reg_rdata; reg_addr = 8'h0B;
    endtask

    task automatic poll(output int n);
        n = 0;
        do begin @(negedge clk); reg_addr = 8'h0B; #1; n++; end
        while (reg_rdata[0] && n < 1000);
    endtask

    task automatic rd_word(output logic [15:0] w);
        logic [7:0] lo, hi;
        rd(8'h0D, lo); rd(8'h0E, hi); w = {hi, lo};
    endtask

    task automatic finish_run;
        if (!fin) begin
            fin = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0]  b;
        logic [15:0] w;
        int          n, ps;
        repeat (4) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        rd(8'h0B, b); chk("R1 ctrl", {8'h0, b}, 16'h0000);
        rd(8'h0C, b); chk("R1 addr", {8'h0, b}, 16'h0000);
        rd_word(w);   chk("R1 data", w, 16'h0000);
        chk("R1 req", {14'h0, phy_req, rom_req}, 16'h0000);
        // R2 map and unmapped address
        wr(8'h0C, 8'h85); rd(8'h0C, b); chk("R2 addr", {8'h0, b}, 16'h0085);
        wr(8'h20, 8'h3F); rd(8'h20, b); chk("R2 unmapped", {8'h0, b}, 16'h0000);
        rd(8'h0C, b); chk("R2 addr kept", {8'h0, b}, 16'h0085);
        // R7 EEPROM write, R3 busy the cycle after the command
        wr(8'h0D, 8'h34); wr(8'h0E, 8'h12); wr(8'h0C, 8'h05); wr(8'h0B, 8'h12);
        rd(8'h0B, b); chk("R3 busy after write", {8'h0, b}, 16'h0013);
        poll(n); chk("R7 rom word", rom_mem[5], 16'h1234);
        wr(8'h0B, 8'h00);
        // R4 write without qualifier starts nothing
        wr(8'h0D, 8'hEF); wr(8'h0E, 8'hBE); wr(8'h0C, 8'h06); wr(8'h0B, 8'h02);
        rd(8'h0B, b); chk("R4 no start", {8'h0, b}, 16'h0002);
        repeat (8) @(negedge clk);
        chk("R4 rom untouched", rom_mem[6], 16'hC006);
        // R3 EEPROM read
        wr(8'h0C, 8'h05); wr(8'h0B, 8'h04); poll(n);
        rd_word(w); chk("R3 rom read", w, 16'h1234);
        // R5 PHY write goes only to PHY
        wr(8'h0D, 8'h5A); wr(8'h0E, 8'h5A); wr(8'h0C, 8'h4A); wr(8'h0B, 8'h1A); poll(n);
        chk("R5 phy word", phy_mem[10], 16'h5A5A);
        chk("R5 rom not hit", rom_mem[10], 16'hC00A);
        wr(8'h0D, 8'h00); wr(8'h0B, 8'h0C); poll(n);
        rd_word(w); chk("R5 phy read", w, 16'h5A5A);
        // R4 read wins over write bits
        wr(8'h0D, 8'h11); wr(8'h0E, 8'h11); wr(8'h0C, 8'h43); wr(8'h0B, 8'h1E); poll(n);
        rd_word(w); chk("R4 read priority data", w, 16'hA003);
        chk("R4 read priority store", phy_mem[3], 16'hA003);
        // R8 foreign PHY number
        ps = phy_starts;
        wr(8'h0C, 8'h8A); wr(8'h0B, 8'h0C);
        rd(8'h0B, b); chk("R8 busy one cycle", {8'h0, b}, 16'h000D);
        @(negedge clk); rd(8'h0B, b); chk("R8 done", {8'h0, b}, 16'h000C);
        rd_word(w); chk("R8 read ones", w, 16'hFFFF);
        wr(8'h0D, 8'h77); wr(8'h0E, 8'h77); wr(8'h0C, 8'hCA); wr(8'h0B, 8'h1A); poll(n);
        chk("R8 write dropped", phy_mem[10], 16'h5A5A);
        chk("R8 no phy request", 16'(phy_starts - ps), 16'h0000);
        // R9 writes while busy are dropped
        ps = phy_starts;
        wr(8'h0C, 8'h07); wr(8'h0B, 8'h04);
        wr(8'h0C, 8'h22); wr(8'h0B, 8'h0C); wr(8'h0D, 8'h99);
        poll(n);
        rd(8'h0C, b); chk("R9 addr kept", {8'h0, b}, 16'h0007);
        rd_word(w);   chk("R9 data from rom", w, 16'hC007);
        rd(8'h0B, b); chk("R9 ctrl kept", {8'h0, b}, 16'h0004);
        chk("R9 no phy request", 16'(phy_starts - ps), 16'h0000);
        // R11 clear
        wr(8'h0B, 8'h00); rd(8'h0B, b); chk("R11 cleared", {8'h0, b}, 16'h0000);
        // R10 timeout
        rom_dead = 1;
        wr(8'h0C, 8'h03); wr(8'h0B, 8'h04); poll(n);
        chk("R10 busy length", 16'(n), 16'(TMO));
        rd_word(w); chk("R10 read ones", w, 16'hFFFF);
        rom_dead = 0;
        wr(8'h0B, 8'h00);
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule